// File: doc/BRIEF.md
# Thermal Margin Threshold Monitor

This block takes one absolute die temperature sample at a time and reports how far it lies below a programmable maximum junction temperature. The reported distance saturates at zero, so a die at or above its limit reads as zero headroom. A zero reading is the point at which the thermal control logic trips.

The registered margin is compared against a configurable number of software thresholds. Each threshold keeps a hot/cool side state with one sample of hysteresis, and it latches a sticky event bit for each crossing direction. The block also watches for a sustained overheat. The trip input from the thermal control logic must stay active and the margin must stay zero for a programmable number of consecutive samples. When that happens, a live out-of-spec status rises and a sticky copy latches.

Sticky bits are cleared by writing ones. A single interrupt line reflects the enabled sticky bits.

Top module: `thermal_margin_monitor`

## Requirements
- R1: One cycle after a clock edge with `sample_valid` high and `sample_temp` below `max_temp`, `margin` equals `max_temp - sample_temp`. It holds that value until the next valid sample.
- R2: When the sample is equal to or above `max_temp`, `margin` reads 0.
- R3: Threshold k is on its hot side when margin <= its level (bits [8k+7:8k] of `thr_level`). `thr_side[k]` changes only after two consecutive valid samples agree on the new side, and it is updated two cycles after the second of them. A single sample on the other side leaves it unchanged.
- R4: When threshold k flips to hot, sticky bit 2k is set. When it flips to cool, sticky bit 2k+1 is set.
- R5: `irq` is high whenever an enabled sticky bit is set. `thr_irq_en[k]` enables sticky bits 2k and 2k+1. A disabled bit still latches but does not drive `irq`.
- R6: `oos_live` rises when `trip_in` is high and the margin is zero on `persist_lim` consecutive valid samples; a limit of 0 acts as 1. Any valid sample that breaks the condition resets the run and drops `oos_live`.
- R7: When `oos_live` rises, sticky bit 4 (the bit after the threshold bits) is set. That bit always drives `irq`.
- R8: A one on bit i of `sticky_clr` for one cycle clears sticky bit i, unless its condition is present in that cycle. For the out-of-spec bit the condition is `oos_live`; for a crossing bit it is a new crossing.
- R9: While `rst` is high, `margin`, `thr_side`, `oos_live`, `sticky` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Qualifies `sample_temp` for one cycle |
| sample_temp | input | 8 | Absolute temperature in degrees, unsigned |
| max_temp | input | 8 | Maximum junction temperature |
| thr_level | input | 16 | Margin thresholds, 8 bits per threshold |
| thr_irq_en | input | 2 | Interrupt enable per threshold |
| persist_lim | input | 4 | Consecutive samples needed for out-of-spec |
| trip_in | input | 1 | Trip from the thermal control logic |
| sticky_clr | input | 5 | Write-one-to-clear strobes for the sticky bits |
| margin | output | 8 | Saturated distance below maximum |
| thr_side | output | 2 | Live hot side per threshold |
| oos_live | output | 1 | Live out-of-spec status |
| sticky | output | 5 | Sticky event bits |
| irq | output | 1 | Interrupt |

## Verification
A wrong hysteresis candidate or side state shows up on `thr_side` and on the crossing sticky bits two cycles after the second agreeing sample. It shows as a flip that comes one sample too early, or as a flip that is missed. A persistence counter that is off by one moves the rise of `oos_live` by a whole sample period. A clear-gating fault either leaves a sticky bit set when no condition is present, or loses it while `oos_live` is still high. Either fault is visible on `sticky` and `irq` in the cycle after the clear strobe.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int TEMP_W = 8;

    typedef logic [TEMP_W-1:0] temp_t;

    typedef struct packed {
        logic  valid;
        temp_t value;
    } margin_s;

    typedef enum logic {
        SIDE_COOL = 1'b0,
        SIDE_HOT  = 1'b1
    } side_e;

    function automatic temp_t headroom(input temp_t t, input temp_t limit);
        return (t >= limit) ? '0 : temp_t'(limit - t);
    endfunction

    function automatic int unsigned sticky_count(input int unsigned nthr);
        return 2 * nthr + 1;
    endfunction

endpackage

// File: rtl/tmon_margin.sv
module tmon_margin
    import tmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sample_valid,
    input  temp_t   sample_temp,
    input  temp_t   max_temp,
    output margin_s margin_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            margin_q <= '0;
        end else begin
            margin_q.valid <= sample_valid;
            if (sample_valid)
                margin_q.value <= headroom(sample_temp, max_temp);
        end
    end
endmodule

// File: rtl/tmon_threshold.sv
module tmon_threshold
    import tmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  margin_s margin_in,
    input  temp_t   level,
    output side_e   side_q,
    output logic    went_hot,
    output logic    went_cool
);
    side_e raw_side;
    side_e cand_q;
    logic  flip;

    always_comb begin
        raw_side  = (margin_in.value <= level) ? SIDE_HOT : SIDE_COOL;
        flip      = margin_in.valid && (raw_side != side_q) && (raw_side == cand_q);
        went_hot  = flip && (raw_side == SIDE_HOT);
        went_cool = flip && (raw_side == SIDE_COOL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_q <= SIDE_COOL;
            cand_q <= SIDE_COOL;
        end else if (margin_in.valid) begin
            cand_q <= raw_side;
            if (flip)
                side_q <= raw_side;
        end
    end
endmodule

// File: rtl/tmon_overheat.sv
module tmon_overheat
    import tmon_pkg::*;
#(
    parameter int PERSIST_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  margin_s              margin_in,
    input  logic                 trip_in,
    input  logic [PERSIST_W-1:0] persist_lim,
    output logic                 oos_q,
    output logic                 oos_event
);
    localparam logic [PERSIST_W-1:0] CNT_MAX = '1;
    localparam logic [PERSIST_W-1:0] ONE     = PERSIST_W'(1);

    logic [PERSIST_W-1:0] run_q, run_next, lim_eff;
    logic                 cond, oos_next;

    always_comb begin
        lim_eff  = (persist_lim == '0) ? ONE : persist_lim;
        cond     = trip_in && (margin_in.value == '0);
        run_next = run_q;
        oos_next = oos_q;
        if (margin_in.valid) begin
            if (cond)
                run_next = (run_q == CNT_MAX) ? run_q : run_q + ONE;
            else
                run_next = '0;
            oos_next = cond && (run_next >= lim_eff);
        end
        oos_event = oos_next && !oos_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            oos_q <= 1'b0;
        end else begin
            run_q <= run_next;
            oos_q <= oos_next;
        end
    end
endmodule

// File: rtl/tmon_sticky.sv
module tmon_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] hold,
    input  logic [N-1:0] clr,
    output logic [N-1:0] bits_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits_q[i] <= 1'b0;
            else if (set[i])
                bits_q[i] <= 1'b1;
            else if (clr[i] && !hold[i])
                bits_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/thermal_margin_monitor.sv
module thermal_margin_monitor
    import tmon_pkg::*;
#(
    parameter int NUM_THR   = 2,
    parameter int PERSIST_W = 4,
    localparam int NSTICKY  = 2 * NUM_THR + 1,
    localparam int OOS_BIT  = 2 * NUM_THR
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sample_valid,
    input  logic [TEMP_W-1:0]           sample_temp,
    input  logic [TEMP_W-1:0]           max_temp,
    input  logic [NUM_THR*TEMP_W-1:0]   thr_level,
    input  logic [NUM_THR-1:0]          thr_irq_en,
    input  logic [PERSIST_W-1:0]        persist_lim,
    input  logic                        trip_in,
    input  logic [NSTICKY-1:0]          sticky_clr,
    output logic [TEMP_W-1:0]           margin,
    output logic [NUM_THR-1:0]          thr_side,
    output logic                        oos_live,
    output logic [NSTICKY-1:0]          sticky,
    output logic                        irq
);
    margin_s            m_q;
    logic [NSTICKY-1:0] set_v, hold_v, mask_v;
    logic               oos_ev;

    tmon_margin u_margin (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_temp  (sample_temp),
        .max_temp     (max_temp),
        .margin_q     (m_q)
    );

    for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
        side_e s;
        logic  hot, cool;
        tmon_threshold u_thr (
            .clk       (clk),
            .rst       (rst),
            .margin_in (m_q),
            .level     (thr_level[k*TEMP_W +: TEMP_W]),
            .side_q    (s),
            .went_hot  (hot),
            .went_cool (cool)
        );
        assign thr_side[k]      = (s == SIDE_HOT);
        assign set_v[2*k]       = hot;
        assign set_v[2*k+1]     = cool;
        assign hold_v[2*k]      = hot;
        assign hold_v[2*k+1]    = cool;
        assign mask_v[2*k]      = thr_irq_en[k];
        assign mask_v[2*k+1]    = thr_irq_en[k];
    end

    tmon_overheat #(.PERSIST_W(PERSIST_W)) u_oos (
        .clk         (clk),
        .rst         (rst),
        .margin_in   (m_q),
        .trip_in     (trip_in),
        .persist_lim (persist_lim),
        .oos_q       (oos_live),
        .oos_event   (oos_ev)
    );

    assign set_v[OOS_BIT]  = oos_ev;
    assign hold_v[OOS_BIT] = oos_live | oos_ev;
    assign mask_v[OOS_BIT] = 1'b1;

    tmon_sticky #(.N(NSTICKY)) u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set    (set_v),
        .hold   (hold_v),
        .clr    (sticky_clr),
        .bits_q (sticky)
    );

    assign margin = m_q.value;
    assign irq    = |(sticky & mask_v);
endmodule

// File: rtl/tmon_checker.sv
module tmon_checker #(
    parameter int NUM_THR = 2,
    localparam int NSTICKY = 2 * NUM_THR + 1,
    localparam int OOS_BIT = 2 * NUM_THR
) (
    input logic               clk,
    input logic               rst,
    input logic               sample_valid,
    input logic [7:0]         sample_temp,
    input logic [7:0]         max_temp,
    input logic [7:0]         margin,
    input logic [NUM_THR-1:0] thr_side,
    input logic               oos_live,
    input logic [NSTICKY-1:0] sticky,
    input logic [NSTICKY-1:0] sticky_clr,
    input logic               irq
);
    AST_MARGIN_DIFF: assert property (@(posedge clk) disable iff (rst)
        $past(sample_valid) && ($past(sample_temp) < $past(max_temp))
        |-> margin == 8'($past(max_temp) - $past(sample_temp))); // R1

    AST_MARGIN_SAT: assert property (@(posedge clk) disable iff (rst)
        $past(sample_valid) && ($past(sample_temp) >= $past(max_temp))
        |-> margin == 8'd0); // R2

    AST_SIDE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(thr_side) |-> $past(sample_valid, 2)); // R3

    AST_OOS_LATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(oos_live) |-> sticky[OOS_BIT]); // R7

    AST_OOS_IRQ: assert property (@(posedge clk) disable iff (rst)
        sticky[OOS_BIT] |-> irq); // R7

    AST_OOS_HOLD: assert property (@(posedge clk) disable iff (rst)
        sticky[OOS_BIT] && oos_live |=> sticky[OOS_BIT]); // R8

    AST_KEEP_UNCLEARED: assert property (@(posedge clk) disable iff (rst)
        sticky[OOS_BIT] && !sticky_clr[OOS_BIT] |=> sticky[OOS_BIT]); // R8

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> sticky != '0); // R5
endmodule

bind thermal_margin_monitor tmon_checker #(.NUM_THR(NUM_THR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .sample_temp  (sample_temp),
    .max_temp     (max_temp),
    .margin       (margin),
    .thr_side     (thr_side),
    .oos_live     (oos_live),
    .sticky       (sticky),
    .sticky_clr   (sticky_clr),
    .irq          (irq)
);

// File: tb/thermal_margin_monitor_test.sv
`timescale 1ns/1ps
module thermal_margin_monitor_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [7:0]  sample_temp, max_temp;
    logic [15:0] thr_level;
    logic [1:0]  thr_irq_en;
    logic [3:0]  persist_lim;
    logic        trip_in;
    logic [4:0]  sticky_clr;
    logic [7:0]  margin;
    logic [1:0]  thr_side;
    logic        oos_live;
    logic [4:0]  sticky;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    thermal_margin_monitor uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_temp(sample_temp),
        .max_temp(max_temp), .thr_level(thr_level), .thr_irq_en(thr_irq_en),
        .persist_lim(persist_lim), .trip_in(trip_in), .sticky_clr(sticky_clr),
        .margin(margin), .thr_side(thr_side), .oos_live(oos_live),
        .sticky(sticky), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; sample_valid = 0; sample_temp = 0; max_temp = 8'd100;
        thr_level = {8'd5, 8'd20}; thr_irq_en = 2'b11; persist_lim = 4'd3;
        trip_in = 0; sticky_clr = '0;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] t);
        sample_temp = t; sample_valid = 1;
        @(negedge clk);
        sample_valid = 0;
        @(negedge clk);
    endtask

    task automatic clear(input logic [4:0] m);
        sticky_clr = m;
        @(negedge clk);
        sticky_clr = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        check("R9 margin", margin, 0);
        check("R9 sticky", sticky, 0);
        check("R9 side", thr_side, 0);
        check("R9 oos", oos_live, 0);
        check("R9 irq", irq, 0);
        rst = 0;
    endtask

    task automatic t_margin();
        do_reset();
        send(8'd70);  check("R1 margin 30", margin, 30);
        send(8'd99);  check("R1 margin 1", margin, 1);
        send(8'd100); check("R2 at max", margin, 0);
        send(8'd255); check("R2 above max", margin, 0);
        repeat (3) @(negedge clk);
        check("R1 margin held", margin, 0);
    endtask

    task automatic t_hyst();
        do_reset();
        send(8'd85);
        check("R3 single sample no flip", thr_side, 0);
        check("R3 no sticky", sticky, 0);
        send(8'd50);
        send(8'd85);
        check("R3 first of pair", thr_side, 0);
        send(8'd85);
        check("R3 side hot", thr_side, 1);
        check("R4 hot sticky", sticky, 5'b00001);
        check("R5 irq enabled", irq, 1);
        clear(5'b00001);
        check("R8 w1c clears", sticky, 0);
        check("R8 irq drops", irq, 0);
        send(8'd50);
        check("R3 single cool no flip", thr_side, 1);
        send(8'd50);
        check("R3 side cool", thr_side, 0);
        check("R4 cool sticky", sticky, 5'b00010);
    endtask

    task automatic t_enable();
        do_reset();
        thr_irq_en = 2'b00;
        send(8'd97);
        send(8'd97);
        check("R4 both hot", sticky, 5'b00101);
        check("R5 disabled no irq", irq, 0);
        thr_irq_en = 2'b10;
        #1;
        check("R5 enable thr1 irq", irq, 1);
    endtask

    task automatic t_oos();
        do_reset();
        thr_irq_en = 2'b00;
        trip_in = 1;
        send(8'd100);
        send(8'd100);
        check("R6 below limit", oos_live, 0);
        check("R7 no sticky yet", sticky[4], 0);
        send(8'd110);
        check("R6 oos rises", oos_live, 1);
        check("R7 oos sticky", sticky[4], 1);
        check("R7 oos irq", irq, 1);
        clear(5'b10000);
        check("R8 clear blocked while live", sticky[4], 1);
        trip_in = 0;
        send(8'd100);
        check("R6 drops without trip", oos_live, 0);
        clear(5'b10000);
        check("R8 clear after drop", sticky[4], 0);
        check("R8 irq after clear", irq, 0);
        trip_in = 1; persist_lim = 4'd2;
        send(8'd100);
        send(8'd99);
        send(8'd100);
        check("R6 run broken by margin", oos_live, 0);
        persist_lim = 4'd0;
        send(8'd100);
        check("R6 limit zero acts as one", oos_live, 1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; sample_valid = 0; sample_temp = 0; max_temp = 8'd100;
        thr_level = {8'd5, 8'd20}; thr_irq_en = 2'b11; persist_lim = 4'd3;
        trip_in = 0; sticky_clr = '0;
        t_reset();
        t_margin();
        t_hyst();
        t_enable();
        t_oos();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule